// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general registers and status words of a 32-bit processor core that runs in seven operating modes. Software always addresses sixteen logical registers with a 4-bit index. Behind that index the block keeps 31 physical general registers. It routes each access to the copy that belongs to the active mode. Fast-interrupt mode has private copies of registers 8 to 14. The IRQ, Supervisor, Abort and Undefined modes each have private copies of registers 13 and 14 only. User and System modes share one view. Registers 0 to 7 and register 15 have a single copy that every mode sees.

The active mode is the 5-bit field in the low bits of the current status word. That word is held inside the block and comes out of reset in Supervisor mode. The block also holds one saved-status word for each of the five exception modes. A saved-status port reads and writes the word that belongs to the active mode. On an exception-entry strobe, three things happen in one clock:
- the current status word is copied into the target mode's saved-status word;
- the return address lands in the target mode's register 14;
- the mode field switches to the target mode.

Every port is a plain control or data pin. Reads are combinational. All writes take effect at the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: While rst_n is low and after it is released, sr_q equals 32'h0000_00D3, which is Supervisor mode 5'b10011 in bits [4:0]. Every general register reads 0, every saved-status word is 0, and ss_err, exc_err and mode_illegal are 0.
- R2: Logical registers 0 to 7 and register 15 have one physical copy that every mode reads and writes.
- R3: In FIQ mode (5'b10001), registers 8 to 14 use copies of their own. Writing them leaves the values that other modes see unchanged.
- R4: IRQ (5'b10010), Supervisor (5'b10011), Abort (5'b10111) and Undefined (5'b11011) each have their own register 13 and register 14. Registers 8 to 12 are the ones User mode uses.
- R5: System mode (5'b11111) uses exactly the registers of User mode (5'b10000).
- R6: Both read ports return, in the same cycle, the value stored for the index in the active mode. A write with wr_en appears on the read ports from the next cycle on.
- R7: In an exception mode, ss_rd_data shows that mode's own saved-status word, and ss_wr_en loads it. The five words are independent of one another.
- R8: In User mode, System mode or an illegal mode, ss_rd_data reads 0 and ss_wr_en changes nothing. Any ss_rd_en or ss_wr_en in those modes raises ss_err for exactly the following cycle.
- R9: When exc_en is high and exc_mode is an exception mode, the next edge does three things: the target's saved-status word receives the old sr_q, the target's register 14 receives exc_ret, and sr_q[4:0] becomes exc_mode while bits [31:5] keep their value. Any wr_en, sr_wr_en or ss_wr_en in that cycle is dropped.
- R10: When exc_en is high and exc_mode is not one of the five exception modes, no register or status word changes. exc_err is high for the following cycle.
- R11: A mode field outside the seven legal codes drives mode_illegal high while it stays. Register accesses in that mode go to the User copies.
- R12: When sr_wr_en is high, sr_q takes sr_wr_data at the next edge, and the mode field switches with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| sr_wr_en | input | 1 | Current status word load |
| sr_wr_data | input | 32 | New current status word |
| sr_q | output | 32 | Current status word; bits [4:0] hold the mode |
| mode_illegal | output | 1 | Mode field holds no legal code |
| ss_rd_en | input | 1 | Saved-status read strobe |
| ss_wr_en | input | 1 | Saved-status write strobe |
| ss_wr_data | input | 32 | Saved-status write data |
| ss_rd_data | output | 32 | Saved-status word of the active mode |
| ss_err | output | 1 | One-cycle pulse after a saved-status access with no saved word |
| exc_en | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode of the exception |
| exc_ret | input | 32 | Return address for the target's register 14 |
| exc_err | output | 1 | One-cycle pulse after an entry to a non-exception mode |

## Verification
The bench fills every bank with a distinct pattern and then sweeps all sixteen indices in each mode. A wrong remap shows up as another mode's value. Examples are FIQ register 12 leaking into User mode, or System mode getting a private stack pointer. Saved-status accesses in User, System and an illegal mode are aimed at the cases where a design would corrupt a saved word or forget the error pulse. Exception entries are issued together with ordinary writes. A design that let those writes through, saved the status after the mode switch, or put the return address into the old mode's register 14 would give different read and status values. Entries toward System, User and illegal codes must leave every register unchanged.

// File: rtl/brf_pkg.sv
package brf_pkg;

  localparam int unsigned IDX_W     = 4;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned NUM_LOW   = 8;
  localparam int unsigned NUM_HI    = 5;
  localparam int unsigned NUM_BANKS = 6;
  localparam int unsigned NUM_SAVED = NUM_BANKS - 1;
  localparam int unsigned IDX_SP    = 13;
  localparam int unsigned IDX_LR    = 14;
  localparam int unsigned IDX_PC    = 15;

  // physical slot layout
  localparam int unsigned FIQ_HI_BASE = NUM_LOW + NUM_HI;
  localparam int unsigned SPLR_BASE   = NUM_LOW + 2 * NUM_HI;
  localparam int unsigned PC_SLOT     = SPLR_BASE + 2 * NUM_BANKS;
  localparam int unsigned NUM_GPR     = PC_SLOT + 1;
  localparam int unsigned PHYS_W      = $clog2(NUM_GPR);
  localparam int unsigned BANK_W      = $clog2(NUM_BANKS);
  localparam int unsigned SAV_W       = $clog2(NUM_SAVED);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [BANK_W-1:0] BK_USR = BANK_W'(0);
  localparam logic [BANK_W-1:0] BK_FIQ = BANK_W'(1);
  localparam logic [BANK_W-1:0] BK_IRQ = BANK_W'(2);
  localparam logic [BANK_W-1:0] BK_SVC = BANK_W'(3);
  localparam logic [BANK_W-1:0] BK_ABT = BANK_W'(4);
  localparam logic [BANK_W-1:0] BK_UND = BANK_W'(5);

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic              has_saved;
    logic              illegal;
  } mode_info_t;

  // logical index + bank -> physical general register slot
  function automatic logic [PHYS_W-1:0] phys_slot(input logic [IDX_W-1:0] idx,
                                                  input logic [BANK_W-1:0] bank);
    int unsigned i;
    int unsigned slot;
    i = 32'(idx);
    if (i == IDX_PC)                slot = PC_SLOT;
    else if (i < NUM_LOW)           slot = i;
    else if (i < NUM_LOW + NUM_HI)  slot = (bank == BK_FIQ) ? FIQ_HI_BASE + (i - NUM_LOW) : i;
    else                            slot = SPLR_BASE + 2 * 32'(bank) + (i - IDX_SP);
    return PHYS_W'(slot);
  endfunction

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_info_t        info
);

  always_comb begin
    info = '{bank: BK_USR, has_saved: 1'b0, illegal: 1'b0};
    case (mode)
      MODE_USR, MODE_SYS: info.bank = BK_USR;
      MODE_FIQ: info = '{bank: BK_FIQ, has_saved: 1'b1, illegal: 1'b0};
      MODE_IRQ: info = '{bank: BK_IRQ, has_saved: 1'b1, illegal: 1'b0};
      MODE_SVC: info = '{bank: BK_SVC, has_saved: 1'b1, illegal: 1'b0};
      MODE_ABT: info = '{bank: BK_ABT, has_saved: 1'b1, illegal: 1'b0};
      MODE_UND: info = '{bank: BK_UND, has_saved: 1'b1, illegal: 1'b0};
      default:  info.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/brf_index_map.sv
module brf_index_map
  import brf_pkg::*;
#(
  parameter int unsigned N_PORTS = 3
) (
  input  logic [N_PORTS-1:0][IDX_W-1:0]  idx,
  input  logic [N_PORTS-1:0][BANK_W-1:0] bank,
  output logic [N_PORTS-1:0][PHYS_W-1:0] slot
);

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    assign slot[g] = phys_slot(idx[g], bank[g]);
  end

endmodule

// File: rtl/brf_gpr_array.sv
module brf_gpr_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned N_RD   = 2,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 waddr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [N_RD-1:0][ADDR_W-1:0]       raddr,
  output logic [N_RD-1:0][DATA_W-1:0]       rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we && (32'(waddr) < DEPTH)) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata[g] = (32'(raddr[g]) < DEPTH) ? mem_q[raddr[g]] : '0;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) we |=> mem_q[$past(waddr)] == $past(wdata)); // R6

endmodule

// File: rtl/brf_status_bank.sv
module brf_status_bank
  import brf_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] RESET_SR = DATA_W'(32'h0000_00D3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mode_info_t         cur_info,
  input  mode_info_t         tgt_info,
  input  logic               exc_en,
  input  logic [MODE_W-1:0]  exc_mode,
  input  logic               sr_wr_en,
  input  logic [DATA_W-1:0]  sr_wr_data,
  input  logic               ss_rd_en,
  input  logic               ss_wr_en,
  input  logic [DATA_W-1:0]  ss_wr_data,
  output logic [DATA_W-1:0]  sr_q,
  output logic [DATA_W-1:0]  ss_rd_data,
  output logic               ss_err,
  output logic               exc_err,
  output logic               exc_ok
);

  logic [NUM_SAVED-1:0][DATA_W-1:0] saved_q;
  logic [SAV_W-1:0] cur_slot, tgt_slot;

  assign cur_slot   = cur_info.has_saved ? SAV_W'(cur_info.bank - BANK_W'(1)) : '0;
  assign tgt_slot   = tgt_info.has_saved ? SAV_W'(tgt_info.bank - BANK_W'(1)) : '0;
  assign exc_ok     = exc_en && tgt_info.has_saved;
  assign ss_rd_data = cur_info.has_saved ? saved_q[cur_slot] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= RESET_SR;
      saved_q <= '0;
      ss_err  <= 1'b0;
      exc_err <= 1'b0;
    end else begin
      ss_err  <= (ss_rd_en || ss_wr_en) && !cur_info.has_saved;
      exc_err <= exc_en && !tgt_info.has_saved;
      if (exc_ok) begin
        saved_q[tgt_slot]  <= sr_q;
        sr_q[MODE_W-1:0]   <= exc_mode;
      end else if (!exc_en) begin
        if (sr_wr_en) sr_q <= sr_wr_data;
        if (ss_wr_en && cur_info.has_saved) saved_q[cur_slot] <= ss_wr_data;
      end
    end
  end

  AST_EXC_SAVES_SR: assert property (@(posedge clk) disable iff (!rst_n) exc_ok |=> saved_q[$past(tgt_slot)] == $past(sr_q)); // R9
  AST_EXC_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n) exc_ok |=> (sr_q[MODE_W-1:0] == $past(exc_mode)) && (sr_q[DATA_W-1:MODE_W] == $past(sr_q[DATA_W-1:MODE_W]))); // R9
  AST_BAD_EXC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (exc_en && !tgt_info.has_saved) |=> exc_err && $stable(sr_q) && $stable(saved_q)); // R10
  AST_NO_SAVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (ss_wr_en && !exc_en && !cur_info.has_saved) |=> ss_err && $stable(saved_q)); // R8
  AST_SR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (sr_wr_en && !exc_en) |=> sr_q == $past(sr_wr_data)); // R12

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_SR = DATA_W'(32'h0000_00D3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_a_idx,
  output logic [DATA_W-1:0]  rd_a_data,
  input  logic [IDX_W-1:0]   rd_b_idx,
  output logic [DATA_W-1:0]  rd_b_data,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               sr_wr_en,
  input  logic [DATA_W-1:0]  sr_wr_data,
  output logic [DATA_W-1:0]  sr_q,
  output logic               mode_illegal,
  input  logic               ss_rd_en,
  input  logic               ss_wr_en,
  input  logic [DATA_W-1:0]  ss_wr_data,
  output logic [DATA_W-1:0]  ss_rd_data,
  output logic               ss_err,
  input  logic               exc_en,
  input  logic [MODE_W-1:0]  exc_mode,
  input  logic [DATA_W-1:0]  exc_ret,
  output logic               exc_err
);

  localparam int unsigned N_RD   = 2;
  localparam int unsigned N_MAP  = N_RD + 1;
  localparam int unsigned WR_PORT = N_RD;

  mode_info_t cur_info, tgt_info;
  logic       exc_ok;

  logic [N_MAP-1:0][IDX_W-1:0]  map_idx;
  logic [N_MAP-1:0][BANK_W-1:0] map_bank;
  logic [N_MAP-1:0][PHYS_W-1:0] map_slot;
  logic [N_RD-1:0][PHYS_W-1:0]  rd_slot;
  logic [N_RD-1:0][DATA_W-1:0]  rd_word;

  logic              gpr_we;
  logic [DATA_W-1:0] gpr_wdata;

  brf_mode_decode u_cur_dec (.mode(sr_q[MODE_W-1:0]), .info(cur_info));
  brf_mode_decode u_tgt_dec (.mode(exc_mode),         .info(tgt_info));

  assign mode_illegal = cur_info.illegal;

  always_comb begin
    map_idx[0]       = rd_a_idx;
    map_idx[1]       = rd_b_idx;
    map_idx[WR_PORT] = exc_en ? IDX_W'(IDX_LR) : wr_idx;
    map_bank[0]       = cur_info.bank;
    map_bank[1]       = cur_info.bank;
    map_bank[WR_PORT] = exc_en ? tgt_info.bank : cur_info.bank;
  end

  brf_index_map #(.N_PORTS(N_MAP)) u_map (
    .idx  (map_idx),
    .bank (map_bank),
    .slot (map_slot)
  );

  // exception entry owns the write port; a rejected entry writes nothing
  assign gpr_we    = exc_en ? exc_ok : wr_en;
  assign gpr_wdata = exc_en ? exc_ret : wr_data;

  for (genvar g = 0; g < N_RD; g++) begin : g_rdslot
    assign rd_slot[g] = map_slot[g];
  end

  brf_gpr_array #(.DATA_W(DATA_W), .DEPTH(NUM_GPR), .N_RD(N_RD)) u_gpr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (gpr_we),
    .waddr (map_slot[WR_PORT]),
    .wdata (gpr_wdata),
    .raddr (rd_slot),
    .rdata (rd_word)
  );

  assign rd_a_data = rd_word[0];
  assign rd_b_data = rd_word[1];

  brf_status_bank #(.DATA_W(DATA_W), .RESET_SR(RESET_SR)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_info   (cur_info),
    .tgt_info   (tgt_info),
    .exc_en     (exc_en),
    .exc_mode   (exc_mode),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .ss_rd_en   (ss_rd_en),
    .ss_wr_en   (ss_wr_en),
    .ss_wr_data (ss_wr_data),
    .sr_q       (sr_q),
    .ss_rd_data (ss_rd_data),
    .ss_err     (ss_err),
    .exc_err    (exc_err),
    .exc_ok     (exc_ok)
  );

  AST_ILLEGAL_AS_USER: assert property (@(posedge clk) disable iff (!rst_n) mode_illegal |-> (cur_info.bank == BK_USR) && !cur_info.has_saved); // R11
  AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n) (rd_a_idx == IDX_W'(IDX_PC) && rd_b_idx == IDX_W'(IDX_PC)) |-> rd_a_data == rd_b_data); // R2
  AST_SS_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) ss_err |-> $past(ss_rd_en || ss_wr_en)); // R8

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111, M_BAD = 5'b10100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, sr_wr_data, sr_q, ss_wr_data, ss_rd_data, exc_ret;
  logic        wr_en, sr_wr_en, mode_illegal, ss_rd_en, ss_wr_en, ss_err, exc_en, exc_err;
  logic [4:0]  exc_mode;

  always #4 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_q(sr_q), .mode_illegal(mode_illegal),
    .ss_rd_en(ss_rd_en), .ss_wr_en(ss_wr_en), .ss_wr_data(ss_wr_data), .ss_rd_data(ss_rd_data),
    .ss_err(ss_err), .exc_en(exc_en), .exc_mode(exc_mode), .exc_ret(exc_ret), .exc_err(exc_err)
  );

  // behavioural reference: shared view, fiq high view, per-mode sp/lr/saved
  logic [31:0] m_com [16];
  logic [31:0] m_fiq [16];
  logic [31:0] m_sp  [6];
  logic [31:0] m_lr  [6];
  logic [31:0] m_sav [6];
  logic [31:0] m_sr;
  logic        e_ss_err, e_exc_err;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    run_cmp = 0;

  function automatic int mbank(logic [4:0] m);
    case (m)
      M_FIQ: return 1; M_IRQ: return 2; M_SVC: return 3;
      M_ABT: return 4; M_UND: return 5; default: return 0;
    endcase
  endfunction

  function automatic bit mlegal(logic [4:0] m);
    return (mbank(m) != 0) || (m == M_USR) || (m == M_SYS);
  endfunction

  function automatic logic [31:0] mread(logic [4:0] m, logic [3:0] idx);
    int b;
    b = mbank(m);
    if (b == 1 && idx >= 8 && idx <= 14) return m_fiq[idx];
    if (idx == 13) return m_sp[b];
    if (idx == 14) return m_lr[b];
    return m_com[idx];
  endfunction

  task automatic mwrite(logic [4:0] m, logic [3:0] idx, logic [31:0] d);
    int b;
    b = mbank(m);
    if (b == 1 && idx >= 8 && idx <= 14) m_fiq[idx] = d;
    else if (idx == 13) m_sp[b] = d;
    else if (idx == 14) m_lr[b] = d;
    else m_com[idx] = d;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin m_com[k] = 0; m_fiq[k] = 0; end
      for (int k = 0; k < 6; k++) begin m_sp[k] = 0; m_lr[k] = 0; m_sav[k] = 0; end
      m_sr = 32'h0000_00D3;
      e_ss_err = 0; e_exc_err = 0;
    end else begin
      int b, t;
      logic [4:0] cm;
      cm = m_sr[4:0];
      b  = mbank(cm);
      e_ss_err = (ss_rd_en || ss_wr_en) && (b == 0);
      if (exc_en) begin
        t = mbank(exc_mode);
        e_exc_err = (t == 0);
        if (t != 0) begin
          m_sav[t] = m_sr;
          mwrite(exc_mode, 4'd14, exc_ret);
          m_sr[4:0] = exc_mode;
        end
      end else begin
        e_exc_err = 0;
        if (wr_en) mwrite(cm, wr_idx, wr_data);
        if (sr_wr_en) m_sr = sr_wr_data;
        if (ss_wr_en && b != 0) m_sav[b] = ss_wr_data;
      end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      int b;
      b = mbank(m_sr[4:0]);
      cmp("rd_a_data", rd_a_data, mread(m_sr[4:0], rd_a_idx));
      cmp("rd_b_data", rd_b_data, mread(m_sr[4:0], rd_b_idx));
      cmp("sr_q", sr_q, m_sr);
      cmp("ss_rd_data", ss_rd_data, (b != 0) ? m_sav[b] : 32'h0);
      cmp("ss_err", 32'(ss_err), 32'(e_ss_err));
      cmp("exc_err", 32'(exc_err), 32'(e_exc_err));
      cmp("mode_illegal", 32'(mode_illegal), 32'(!mlegal(m_sr[4:0])));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; sr_wr_en = 0; ss_rd_en = 0; ss_wr_en = 0; exc_en = 0;
  endtask

  task automatic sweep();
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); tick();
    end
  endtask

  task automatic set_mode(logic [4:0] m);
    sr_wr_en = 1; sr_wr_data = {27'h0, m}; tick();
  endtask

  task automatic fill(logic [31:0] base);
    for (int i = 0; i < 16; i++) begin
      wr_en = 1; wr_idx = 4'(i); wr_data = base + 32'(i); rd_a_idx = 4'(i); tick();
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    rst_n = 0; rd_a_idx = 0; rd_b_idx = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    sr_wr_en = 0; sr_wr_data = 0; ss_rd_en = 0; ss_wr_en = 0; ss_wr_data = 0;
    exc_en = 0; exc_mode = 0; exc_ret = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; run_cmp = 1;
    #4 cmp("R1 reset status", sr_q, 32'h0000_00D3);
    cur_req = "R1 reset contents"; sweep();

    cur_req = "R4 R6 supervisor fill"; fill(32'h3000_0000);
    cur_req = "R12 mode load";         set_mode(M_USR);
    cur_req = "R2 user fill";          fill(32'h1000_0000); sweep();
    cur_req = "R12 mode load";         set_mode(M_FIQ);
    cur_req = "R3 fiq fill";           fill(32'h2000_0000); sweep();
    set_mode(M_USR);
    cur_req = "R3 user view intact";   sweep();
    set_mode(M_SVC);
    cur_req = "R4 supervisor view";    sweep();
    set_mode(M_SYS);
    cur_req = "R5 system as user";     sweep();
    wr_en = 1; wr_idx = 13; wr_data = 32'h5555_0013; tick();
    set_mode(M_USR); sweep();

    cur_req = "R4 irq abt und banks";
    for (int k = 0; k < 3; k++) begin
      set_mode(k == 0 ? M_IRQ : (k == 1 ? M_ABT : M_UND));
      wr_en = 1; wr_idx = 13; wr_data = 32'h4000_0D00 + 32'(k); tick();
      wr_en = 1; wr_idx = 14; wr_data = 32'h4000_0E00 + 32'(k); tick();
      wr_en = 1; wr_idx = 9;  wr_data = 32'h4000_0900 + 32'(k); tick();
      sweep();
    end
    set_mode(M_USR); sweep();

    cur_req = "R7 saved words";
    for (int k = 0; k < 5; k++) begin
      logic [4:0] m;
      m = (k == 0) ? M_FIQ : (k == 1) ? M_IRQ : (k == 2) ? M_SVC : (k == 3) ? M_ABT : M_UND;
      set_mode(m);
      ss_wr_en = 1; ss_wr_data = 32'h5A00_0000 | 32'(m); tick();
      ss_rd_en = 1; tick();
    end
    for (int k = 0; k < 5; k++) begin
      set_mode(k == 0 ? M_UND : (k == 1 ? M_ABT : (k == 2 ? M_SVC : (k == 3 ? M_IRQ : M_FIQ))));
      ss_rd_en = 1; tick();
    end

    cur_req = "R8 no saved word";
    set_mode(M_USR);
    ss_wr_en = 1; ss_wr_data = 32'hBAD0_0001; tick(); tick();
    ss_rd_en = 1; tick(); tick();
    set_mode(M_SYS);
    ss_wr_en = 1; ss_rd_en = 1; ss_wr_data = 32'hBAD0_0002; tick(); tick();
    set_mode(M_IRQ); ss_rd_en = 1; tick();

    cur_req = "R11 illegal mode";
    set_mode(M_BAD); sweep();
    wr_en = 1; wr_idx = 10; wr_data = 32'h0BAD_000A; tick();
    ss_wr_en = 1; ss_wr_data = 32'hBAD0_0003; tick(); tick();
    set_mode(M_USR); sweep();

    cur_req = "R9 exception entry";
    sr_wr_en = 1; sr_wr_data = 32'hA000_0010; tick();
    exc_en = 1; exc_mode = M_IRQ; exc_ret = 32'h0000_1234;
    wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_0000;
    sr_wr_en = 1; sr_wr_data = 32'h0000_001F;
    ss_wr_en = 1; ss_wr_data = 32'hDEAD_0001; tick();
    #4 cmp("R9 mode after entry", sr_q, 32'hA000_0012);
    ss_rd_en = 1; sweep();
    exc_en = 1; exc_mode = M_FIQ; exc_ret = 32'h0000_5678; tick();
    ss_rd_en = 1; sweep();
    exc_en = 1; exc_mode = M_UND; exc_ret = 32'h0000_9ABC; wr_en = 1; wr_idx = 14; wr_data = 32'hDEAD_0002; tick();
    sweep();

    cur_req = "R10 rejected entry";
    exc_en = 1; exc_mode = M_SYS; exc_ret = 32'hDEAD_0003; wr_en = 1; wr_idx = 1; wr_data = 32'hDEAD_0004; tick(); tick();
    exc_en = 1; exc_mode = M_USR; exc_ret = 32'hDEAD_0005; sr_wr_en = 1; sr_wr_data = 32'h0000_0010; tick();
    exc_en = 1; exc_mode = 5'b00000; exc_ret = 32'hDEAD_0006; tick(); tick();
    sweep();

    cur_req = "R6 same-cycle read";
    set_mode(M_SVC);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(i);
      wr_en = 1; wr_idx = 4'(i); wr_data = 32'h7700_0000 + 32'(i); tick();
    end
    sweep();

    finish_run();
  end

endmodule